// File: doc/BRIEF.md
# Eight-bit CPU Bus Cycle Sequencer

This block turns one machine-cycle request into the strobe waveforms of a classic 8-bit microprocessor bus. It supports six cycle kinds: opcode fetch, memory read, memory write, I/O read, I/O write and interrupt acknowledge. Each T-state takes two clock periods, a first half (phase 0) and a second half (phase 1), and every strobe edge falls on a half boundary. Inside a cycle, half-T index h = 2*(T-1) + phase, with T counted from 1 in the order the T-states actually occur.

A request carries the kind code, the main address, a refresh address and a write byte. The block latches these on acceptance and then steps through the T-states. It inserts the fixed wait states that I/O and interrupt acknowledge need, and it adds more whenever the wait input is low at the sampling point. Opcode fetch and interrupt acknowledge end with a refresh phase that puts the refresh address on the bus. Read-type cycles capture the input data byte. A one-clock done pulse marks the last half of the cycle, and it comes with the number of T-states the cycle used.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset all six strobes are high, `addr` is 0, `done` is 0 and `req_ready` is 1. While idle, all strobes stay high and `addr` is 0.
- R2: Opcode fetch (kind 0) takes 4 T-states. M1 is low for h 0..3 and RFSH is low for h 4..6. `addr` shows the request address while logical T-state < 3 and the refresh address after that.
- R3: In an opcode fetch, MREQ is low for h 1..3 and again for h 5..6, RD is low for h 1..3, and `rdata` takes `din` at the clock edge that ends h 3.
- R4: Memory read (kind 1) takes 3 T-states. MREQ and RD are low for h 1..4, and `rdata` takes `din` at the edge that ends h 4.
- R5: Memory write (kind 2) takes 3 T-states. MREQ is low for h 1..4, WR is low for h 2..4, `dout_en` is high for h 1..5, and `dout` carries the request byte while `dout_en` is high.
- R6: I/O read (kind 3) and I/O write (kind 4) take 4 T-states, one of them an automatic wait. IORQ and RD (read) or WR (write) are low for h 2..6, and `dout_en` is high for h 1..7 on writes. A read captures `din` at the edge that ends h 6.
- R7: Interrupt acknowledge (kind 5) takes 6 T-states, two of them automatic waits. M1 is low for h 0..7 and IORQ for h 5..7, and `din` is captured at the edge that ends h 7. RFSH is low for h 8..10 and MREQ for h 9..10, with the refresh address on `addr` from logical T-state 5 on.
- R8: `wait_n` is sampled only at the end of phase 1 of the wait-point T-state: logical T2 for fetch and memory, logical T3 for I/O, logical T4 for acknowledge. Each low sample repeats that T-state once with the same strobes. Low values at any other time have no effect.
- R9: `done` is high for exactly the last half of each cycle, and `tcount` then equals the base length plus the number of inserted waits. `req_ready` is high when idle or during `done`, so a request presented during `done` starts in the next clock.
- R10: MREQ, IORQ, RD and WR are high in the first and the last half of every cycle. MREQ and IORQ are never low together, and neither are RD and WR.
- R11: A request with kind code 6 or 7 is ignored: the block stays idle and all strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_type | input | 3 | Cycle kind code 0..5 |
| req_addr | input | AW | Main address (PC, memory or port) |
| req_raddr | input | AW | Refresh address |
| req_wdata | input | DW | Byte to write |
| din | input | DW | Data bus input |
| wait_n | input | 1 | Active-low wait request |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode fetch / acknowledge marker |
| rfsh_n | output | 1 | Refresh strobe |
| addr | output | AW | Address bus |
| dout | output | DW | Write data |
| dout_en | output | 1 | Drive enable for `dout` |
| rdata | output | DW | Last captured read byte |
| done | output | 1 | Last half of a cycle |
| tcount | output | CW | T-states used, valid with `done` |

## Verification
The assertions assume that `wait_n` is a clean, synchronous level and that the wait input is never held low long enough to wrap the T-state counter. The stimulus keeps to this. It changes `wait_n` and `din` only at falling clock edges and never inserts more than two extra waits per cycle. Between sampling points it also drives `wait_n` low on purpose, so that R8's claim that those values are ignored is tested against the reported T-state count.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int KW = 3;

  typedef enum logic [2:0] {
    CY_FETCH = 3'd0,
    CY_MEMRD = 3'd1,
    CY_MEMWR = 3'd2,
    CY_IORD  = 3'd3,
    CY_IOWR  = 3'd4,
    CY_INTA  = 3'd5
  } cyc_e;

  // active-high internal view of the bus controls
  typedef struct packed {
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
    logic m1;
    logic rfsh;
    logic den;
  } strb_t;

  function automatic logic kind_ok(logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // base T-states per kind (R2, R4, R5, R6, R7)
  function automatic logic [KW-1:0] base_len(cyc_e t);
    case (t)
      CY_FETCH: return KW'(4);
      CY_MEMRD, CY_MEMWR: return KW'(3);
      CY_IORD, CY_IOWR: return KW'(4);
      default: return KW'(6);
    endcase
  endfunction

  // logical T-state (0-based) where wait_n is sampled (R8)
  function automatic logic [KW-1:0] wait_point(cyc_e t);
    case (t)
      CY_FETCH, CY_MEMRD, CY_MEMWR: return KW'(1);
      CY_IORD, CY_IOWR: return KW'(2);
      default: return KW'(3);
    endcase
  endfunction

  function automatic logic in_span(logic [KW:0] h, int lo, int hi);
    return (int'(h) >= lo) && (int'(h) <= hi);
  endfunction

  // half-T slot whose ending edge captures din (R3, R4, R6, R7)
  function automatic logic capture_slot(cyc_e t, logic [KW-1:0] k, logic p);
    logic [KW:0] h;
    h = {k, p};
    case (t)
      CY_FETCH: return h == 4'd3;
      CY_MEMRD: return h == 4'd4;
      CY_IORD:  return h == 4'd6;
      CY_INTA:  return h == 4'd7;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic refresh_half(cyc_e t, logic [KW-1:0] k);
    return ((t == CY_FETCH) && (k >= KW'(2))) || ((t == CY_INTA) && (k >= KW'(4)));
  endfunction

  function automatic strb_t strobe_map(cyc_e t, logic [KW-1:0] k, logic p);
    logic [KW:0] h;
    strb_t r;
    h = {k, p};
    r = '0;
    case (t)
      CY_FETCH: begin
        r.m1   = in_span(h, 0, 3);
        r.mreq = in_span(h, 1, 3) || in_span(h, 5, 6);
        r.rd   = in_span(h, 1, 3);
        r.rfsh = in_span(h, 4, 6);
      end
      CY_MEMRD: begin
        r.mreq = in_span(h, 1, 4);
        r.rd   = in_span(h, 1, 4);
      end
      CY_MEMWR: begin
        r.mreq = in_span(h, 1, 4);
        r.wr   = in_span(h, 2, 4);
        r.den  = in_span(h, 1, 5);
      end
      CY_IORD: begin
        r.iorq = in_span(h, 2, 6);
        r.rd   = in_span(h, 2, 6);
      end
      CY_IOWR: begin
        r.iorq = in_span(h, 2, 6);
        r.wr   = in_span(h, 2, 6);
        r.den  = in_span(h, 1, 7);
      end
      default: begin
        r.m1   = in_span(h, 0, 7);
        r.iorq = in_span(h, 5, 7);
        r.rfsh = in_span(h, 8, 10);
        r.mreq = in_span(h, 9, 10);
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcs_timer.sv
module bcs_timer
  import bcs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cyc_e          start_kind,
  input  logic          wait_n,
  output logic          busy,
  output cyc_e          kind,
  output logic [KW-1:0] tstate,
  output logic          phase,
  output logic [CW-1:0] tcnt,
  output logic          hold,
  output logic          last_half
);
  // R8: repeat the wait-point T-state while wait_n is low at its end
  assign hold = busy && phase && (tstate == wait_point(kind)) && !wait_n;
  // R9: final half of the final logical T-state
  assign last_half = busy && phase && (tstate == base_len(kind) - KW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      kind   <= CY_FETCH;
      tstate <= '0;
      phase  <= 1'b0;
      tcnt   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      kind   <= start_kind;
      tstate <= '0;
      phase  <= 1'b0;
      tcnt   <= CW'(1);
    end else if (last_half) begin
      busy   <= 1'b0;
      tstate <= '0;
      phase  <= 1'b0;
    end else if (busy) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        tcnt  <= tcnt + 1'b1;
        if (!hold) tstate <= tstate + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
(
  input  logic          busy,
  input  cyc_e          kind,
  input  logic [KW-1:0] tstate,
  input  logic          phase,
  output strb_t         strb,
  output logic          cap_en,
  output logic          rfsh_addr
);
  always_comb begin
    strb      = '0;
    cap_en    = 1'b0;
    rfsh_addr = 1'b0;
    if (busy) begin
      strb      = strobe_map(kind, tstate, phase);
      cap_en    = capture_slot(kind, tstate, phase);
      rfsh_addr = refresh_half(kind, tstate);
    end
  end
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_raddr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] din,
  input  logic          busy,
  input  logic          rfsh_addr,
  input  logic          cap_en,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] main_q;
  logic [AW-1:0] rfsh_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q  <= '0;
      rfsh_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        main_q  <= req_addr;
        rfsh_q  <= req_raddr;
        wdata_q <= req_wdata;
      end
      if (cap_en) rdata_q <= din;
    end
  end

  assign addr  = !busy ? '0 : (rfsh_addr ? rfsh_q : main_q);
  assign dout  = wdata_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_raddr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] din,
  input  logic          wait_n,
  output logic          mreq_n,
  output logic          iorq_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          m1_n,
  output logic          rfsh_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [CW-1:0] tcount
);
  // named internal events, used by the bound checker
  logic          busy;
  logic          start;
  logic          hold;
  logic          cap_en;
  logic          rfsh_addr;
  cyc_e          kind;
  logic [KW-1:0] tstate;
  logic          phase;
  strb_t         strb;

  // R9 back-to-back acceptance, R11 unknown kinds dropped
  assign req_ready = !busy || done;
  assign start     = req_valid && req_ready && kind_ok(req_type);

  bcs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(cyc_e'(req_type)),
    .wait_n(wait_n), .busy(busy), .kind(kind), .tstate(tstate), .phase(phase),
    .tcnt(tcount), .hold(hold), .last_half(done)
  );

  bcs_decode u_dec (
    .busy(busy), .kind(kind), .tstate(tstate), .phase(phase),
    .strb(strb), .cap_en(cap_en), .rfsh_addr(rfsh_addr)
  );

  bcs_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .req_raddr(req_raddr), .req_wdata(req_wdata), .din(din), .busy(busy),
    .rfsh_addr(rfsh_addr), .cap_en(cap_en), .addr(addr), .dout(dout), .rdata(rdata)
  );

  assign mreq_n  = !strb.mreq;
  assign iorq_n  = !strb.iorq;
  assign rd_n    = !strb.rd;
  assign wr_n    = !strb.wr;
  assign m1_n    = !strb.m1;
  assign rfsh_n  = !strb.rfsh;
  assign dout_en = strb.den;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mreq_n,
  input logic          iorq_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          m1_n,
  input logic          rfsh_n,
  input logic          dout_en,
  input logic          busy,
  input logic          hold,
  input logic          done,
  input logic [CW-1:0] tcount
);
  a_r10_mreq_iorq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));

  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n));

  a_r2_rfsh_not_m1: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> m1_n);

  a_r5_wr_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dout_en);

  a_r9_done_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tcount >= CW'(3)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (busy && !done));
endmodule

bind bus_cycle_seq bcs_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
  .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .dout_en(dout_en), .busy(busy),
  .hold(hold), .done(done), .tcount(tcount)
);

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_type = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [15:0] req_raddr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic [7:0]  din = 8'h0;
  logic        wait_n = 1'b1;
  logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, dout_en, done;
  logic [15:0] addr;
  logic [7:0]  dout, rdata, tcount;

  int checks = 0;
  int errors = 0;
  int rd_base = 0;
  bit nxt_valid = 0;
  int nxt_type = 0;

  always #5 clk = ~clk;

  bus_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_raddr(req_raddr),
    .req_wdata(req_wdata), .din(din), .wait_n(wait_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .addr(addr), .dout(dout), .dout_en(dout_en), .rdata(rdata), .done(done),
    .tcount(tcount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit sp(int h, int lo, int hi);
    return h >= lo && h <= hi;
  endfunction

  // expected {mreq,iorq,rd,wr,m1,rfsh,den}, active high, from R2..R7
  function automatic logic [6:0] want(int ty, int h);
    logic mq, io, r, w, m, f, d;
    {mq, io, r, w, m, f, d} = '0;
    if (ty == 0) begin m = sp(h,0,3); r = sp(h,1,3); mq = sp(h,1,3) | sp(h,5,6); f = sp(h,4,6); end
    if (ty == 1) begin mq = sp(h,1,4); r = sp(h,1,4); end
    if (ty == 2) begin mq = sp(h,1,4); w = sp(h,2,4); d = sp(h,1,5); end
    if (ty == 3) begin io = sp(h,2,6); r = sp(h,2,6); end
    if (ty == 4) begin io = sp(h,2,6); w = sp(h,2,6); d = sp(h,1,7); end
    if (ty == 5) begin m = sp(h,0,7); io = sp(h,5,7); f = sp(h,8,10); mq = sp(h,9,10); end
    return {mq, io, r, w, m, f, d};
  endfunction

  function automatic string tag_of(int ty);
    case (ty)
      0: return "R2/R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input int ty, input int a, input int ra, input int wd);
    req_valid = 1'b1;
    req_type  = 3'(ty);
    req_addr  = 16'(a);
    req_raddr = 16'(ra);
    req_wdata = 8'(wd);
  endtask

  // runs one accepted cycle; request already presented; w extra waits
  task automatic run(input int ty, input int w, input bit noisy);
    int len, kw, ck, cp, total, cap_h;
    logic [15:0] a_main, a_rf;
    logic [7:0]  wd;
    len = (ty == 0) ? 4 : (ty <= 2) ? 3 : (ty <= 4) ? 4 : 6;
    kw  = (ty <= 2) ? 1 : (ty <= 4) ? 2 : 3;
    ck  = (ty == 0) ? 1 : (ty == 1) ? 2 : (ty == 3) ? 3 : (ty == 5) ? 3 : -1;
    cp  = (ty == 0 || ty == 5) ? 1 : 0;
    total = len + w;
    cap_h = (ck < 0) ? -1 : 2 * ((ck < kw) ? ck : (ck == kw) ? kw + w : ck + w) + cp;
    a_main = req_addr; a_rf = req_raddr; wd = req_wdata;
    @(posedge clk);
    for (int t = 0; t < total; t++) begin
      for (int p = 0; p < 2; p++) begin
        int k, h;
        bit last;
        logic [6:0] act, exp;
        logic [15:0] ea;
        @(negedge clk);
        h = 2 * t + p;
        k = (t <= kw) ? t : (t <= kw + w) ? kw : t - w;
        last = (t == total - 1) && (p == 1);
        if (t == 0 && p == 0) req_valid = 1'b0;
        act = {~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~m1_n, ~rfsh_n, dout_en};
        exp = want(ty, 2 * k + p);
        chk(act == exp, {tag_of(ty), " strobes"}, int'(act), int'(exp));
        ea = ((ty == 0 && k >= 2) || (ty == 5 && k >= 4)) ? a_rf : a_main;
        chk(addr == ea, {tag_of(ty), " addr"}, int'(addr), int'(ea));
        if (dout_en) chk(dout == wd, "R5/R6 dout", int'(dout), int'(wd));
        if (h == 0 || last)
          chk({mreq_n, iorq_n, rd_n, wr_n} == 4'hF, "R10 edge halves quiet",
              int'({mreq_n, iorq_n, rd_n, wr_n}), 15);
        chk(done == last, "R9 done", int'(done), int'(last));
        chk(req_ready == last, "R9 ready", int'(req_ready), int'(last));
        if (last) begin
          chk(int'(tcount) == total, "R8/R9 tcount", int'(tcount), total);
          if (cap_h >= 0)
            chk(rdata == 8'(rd_base + cap_h), {tag_of(ty), " rdata"}, int'(rdata),
                int'(8'(rd_base + cap_h)));
          if (nxt_valid) begin
            issue(nxt_type, 16'h1000 + nxt_type, 16'h0040 + nxt_type, 8'hA0 + nxt_type);
            nxt_valid = 0;
          end
        end
        din = 8'(rd_base + h);
        if (p == 1 && t >= kw && t < kw + w) wait_n = 1'b0;
        else if (p == 1 && t == kw + w) wait_n = 1'b1;
        else wait_n = noisy ? 1'b0 : 1'b1;
      end
    end
    wait_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n} == 6'h3F, "R1 strobes",
        int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), 63);
    chk(addr == 16'h0, "R1 addr", int'(addr), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

    // R11 unknown kinds
    for (int c = 6; c < 8; c++) begin
      issue(c, 16'h1234, 16'h0055, 8'h11);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n} == 6'h3F && !done,
            "R11 ignored kind", int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, done}), 126);
      end
      req_valid = 1'b0;
    end

    // sweep all kinds, wait counts and wait noise (R2..R8)
    for (int ty = 0; ty < 6; ty++)
      for (int w = 0; w < 3; w++)
        for (int n = 0; n < 2; n++) begin
          rd_base = 16 * ty + 5 * w + 3 * n + 1;
          issue(ty, 16'h8000 + 256 * ty + 16 * w + n, 16'h0070 + ty, 8'h30 + 8 * ty + w);
          run(ty, w, n[0]);
          @(negedge clk);
          chk(addr == 16'h0 && m1_n && rfsh_n && mreq_n, "R1 idle after cycle",
              int'(addr), 0);
        end

    // R9 back-to-back chain: fetch, mem write, io read, ack, mem read
    rd_base = 77;
    issue(0, 16'h4000, 16'h0011, 8'h5A);
    nxt_valid = 1; nxt_type = 2;
    run(0, 1, 1'b1);
    nxt_valid = 1; nxt_type = 3;
    run(2, 0, 1'b0);
    nxt_valid = 1; nxt_type = 5;
    run(3, 2, 1'b1);
    nxt_valid = 1; nxt_type = 1;
    run(5, 1, 1'b0);
    run(1, 2, 1'b1);
    @(negedge clk);
    chk(req_ready && done == 1'b0, "R9 idle after chain", int'({req_ready, done}), 2);
    finish_run();
  end
endmodule